// File: doc/BRIEF.md
# Line-Wide Branch Target Buffer

This block predicts where instruction fetch goes next. It is given a fetch address and looks at the whole 16-byte line that holds it. The entries are kept in a set-associative store, and several branches of one line can sit in different ways of the same set. Each lookup returns a prediction one cycle later. When a qualifying branch exists, the prediction is the target of the first branch predicted taken at or after the fetch offset. Otherwise it is the address of the next sequential line.

Each entry keeps its own short local history. A per-set table of 2-bit saturating counters, indexed by that history, gives the direction of conditional branches. Returns, calls and jumps are always treated as taken. A lookup shifts the predicted outcome into the history of every branch that fetch passes over. When a branch resolves, the update port trains the counter that made the prediction and repairs the history with the real outcome. A resolved branch that is not yet stored takes a way chosen by a per-set round-robin pointer.

Top module: `btb_cluster`

## Requirements
- R1: `predValid` is high exactly in the cycle after a cycle with `lookupValid` high. The other prediction outputs change only in the cycle after a lookup and hold their values otherwise.
- R2: The address fields are: bits [OFF_BITS-1:0] are the line offset, the next SET_BITS bits are the set, and the next TAG_BITS bits are the stored partial tag. Address bits above the tag have no effect on hits.
- R3: When no stored branch qualifies as taken, the outputs are `predTaken`=0, `predKind`=00 and `predOffset`=0, and `predTarget` is the fetch address with its offset bits cleared, plus the line size.
- R4: A way whose tag matches but whose stored offset is below the fetch offset never supplies the prediction.
- R5: Among the matching ways at or after the fetch offset that predict taken, the one with the lowest offset is chosen. Its target, kind and offset are output with `predTaken`=1.
- R6: Kind encoding is 00 conditional, 01 return, 10 call, 11 jump. Every kind other than 00 is predicted taken whatever the counter holds.
- R7: A conditional branch is predicted taken when bit 1 of the counter is set. The counter is the one in its set's table at the index given by the entry's history. Counters reset to 01.
- R8: A lookup affects every matching way at or after the fetch offset and no further than the chosen branch (all of them when none is chosen). For each such way, the lookup saves the way's history and shifts the way's predicted outcome into bit 0. A resolve trains the counter at the saved history, moving up by one if taken and down by one if not, saturating at 00 and 11. It then sets the history to the saved history shifted with the actual outcome.
- R9: An update matches on set, tag and offset, and refreshes the stored target and kind. An update that matches nothing fills the way at the set's round-robin pointer, and the pointer then advances. The new entry's history is the actual outcome in bit 0 with zeros above. The counter at that index is set to 10 if the branch was taken, otherwise to 01.
- R10: If a lookup and an update arrive in the same cycle, the lookup is answered from the state before the update. The update is applied after the lookup's history shift.
- R11: After reset, no entry is valid, and `predValid` and `predTaken` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lookupValid | input | 1 | Lookup strobe |
| lookupIp | input | ADDR_W | Fetch address |
| updValid | input | 1 | Resolved-branch strobe |
| updIp | input | ADDR_W | Address of the resolved branch |
| updTarget | input | ADDR_W | Resolved target |
| updTaken | input | 1 | Actual direction |
| updKind | input | 2 | Branch kind (R6 encoding) |
| predValid | output | 1 | Prediction valid, one cycle after lookup |
| predTaken | output | 1 | A taken branch was found in the line |
| predTarget | output | ADDR_W | Next fetch address |
| predKind | output | 2 | Kind of the chosen branch |
| predOffset | output | OFF_BITS | Line offset of the chosen branch |

## Verification
The bench builds the block with eight sets and keeps the default four ways, 16-byte lines, 9-bit tags and 4-bit histories. This makes three set bits, so a handful of lines reaches every offset of a loaded line, five-way eviction in one set, and same-cycle lookup/update collisions. A pseudo-random stream over two tags and two sets forces counter sharing between branches, history repair and repeated replacement. Every response is compared against an arithmetic model of the stated rules.

// File: rtl/btb_pkg.sv
package btb_pkg;

  typedef enum logic [1:0] {
    KIND_COND = 2'b00,
    KIND_RET  = 2'b01,
    KIND_CALL = 2'b10,
    KIND_JUMP = 2'b11
  } brKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic lookupEn;
    logic trainEn;
    logic allocEn;
  } btbStrobe_t;

  function automatic logic [1:0] satStep(input logic [1:0] cur, input logic up);
    if (up) return (cur == 2'b11) ? cur : cur + 2'b01;
    else    return (cur == 2'b00) ? cur : cur - 2'b01;
  endfunction

endpackage

// File: rtl/btb_pick.sv
module btb_pick #(
  parameter int NUM_WAYS = 4,
  parameter int OFF_BITS = 4,
  localparam int WAY_BITS = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0]               hitVec,
  input  logic [NUM_WAYS-1:0]               predVec,
  input  logic [NUM_WAYS-1:0][OFF_BITS-1:0] wayOff,
  input  logic [OFF_BITS-1:0]               fetchOff,
  output logic                              found,
  output logic [WAY_BITS-1:0]               bestWay,
  output logic [OFF_BITS-1:0]               bestOff,
  output logic [NUM_WAYS-1:0]               travVec
);

  logic [NUM_WAYS-1:0] candVec;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cand
    assign candVec[w] = hitVec[w] && (wayOff[w] >= fetchOff);
  end

  // Leftmost taken candidate
  always_comb begin
    found   = 1'b0;
    bestWay = '0;
    bestOff = '1;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (candVec[w] && predVec[w] && (!found || wayOff[w] < bestOff)) begin
        found   = 1'b1;
        bestWay = WAY_BITS'(w);
        bestOff = wayOff[w];
      end
    end
  end

  // Branches fetch passes over up to and including the chosen one
  always_comb begin
    for (int w = 0; w < NUM_WAYS; w++) begin
      travVec[w] = candVec[w] && (!found || wayOff[w] <= bestOff);
    end
  end

endmodule

// File: rtl/btb_ctrl.sv
module btb_ctrl
  import btb_pkg::*;
#(
  parameter int NUM_SETS = 128,
  parameter int NUM_WAYS = 4,
  localparam int SET_BITS = $clog2(NUM_SETS),
  localparam int WAY_BITS = $clog2(NUM_WAYS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                lookupValid,
  input  logic                updValid,
  input  logic [SET_BITS-1:0] updSet,
  input  logic                updHit,
  input  logic [WAY_BITS-1:0] updHitWay,
  output btbStrobe_t          strobe,
  output logic [WAY_BITS-1:0] writeWay
);

  logic [WAY_BITS-1:0] rrPtr [NUM_SETS];

  always_comb begin
    strobe.lookupEn = lookupValid;
    strobe.trainEn  = updValid && updHit;
    strobe.allocEn  = updValid && !updHit;
    writeWay        = updHit ? updHitWay : rrPtr[updSet];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SETS; s++) rrPtr[s] <= '0;
    end else if (strobe.allocEn) begin
      rrPtr[updSet] <= rrPtr[updSet] + WAY_BITS'(1);
    end
  end

endmodule

// File: rtl/btb_datapath.sv
module btb_datapath
  import btb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_WAYS   = 4,
  parameter int NUM_SETS   = 128,
  parameter int LINE_BYTES = 16,
  parameter int TAG_BITS   = 9,
  parameter int HIST_BITS  = 4,
  localparam int OFF_BITS  = $clog2(LINE_BYTES),
  localparam int SET_BITS  = $clog2(NUM_SETS),
  localparam int WAY_BITS  = $clog2(NUM_WAYS),
  localparam int CTR_COUNT = 1 << HIST_BITS,
  localparam int USED_BITS = OFF_BITS + SET_BITS + TAG_BITS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   lookupIp,
  input  logic [ADDR_W-1:0]   updIp,
  input  logic [ADDR_W-1:0]   updTarget,
  input  logic                updTaken,
  input  logic [1:0]          updKind,
  input  btbStrobe_t          strobe,
  input  logic [WAY_BITS-1:0] writeWay,
  output logic [SET_BITS-1:0] updSet,
  output logic                updHit,
  output logic [WAY_BITS-1:0] updHitWay,
  output logic                predValid,
  output logic                predTaken,
  output logic [ADDR_W-1:0]   predTarget,
  output logic [1:0]          predKind,
  output logic [OFF_BITS-1:0] predOffset
);

  // Entry storage
  logic                 entValid  [NUM_SETS][NUM_WAYS];
  logic [TAG_BITS-1:0]  entTag    [NUM_SETS][NUM_WAYS];
  logic [OFF_BITS-1:0]  entOff    [NUM_SETS][NUM_WAYS];
  logic [ADDR_W-1:0]    entTarget [NUM_SETS][NUM_WAYS];
  logic [1:0]           entKind   [NUM_SETS][NUM_WAYS];
  logic [HIST_BITS-1:0] entHist   [NUM_SETS][NUM_WAYS];
  logic [HIST_BITS-1:0] entLast   [NUM_SETS][NUM_WAYS];
  logic [1:0]           ctrTab    [NUM_SETS][CTR_COUNT];

  // Address fields
  logic [OFF_BITS-1:0] lkOff, upOff;
  logic [SET_BITS-1:0] lkSet;
  logic [TAG_BITS-1:0] lkTag, upTag;
  logic [ADDR_W-1:0]   nextLine;

  assign lkOff    = lookupIp[OFF_BITS-1:0];
  assign lkSet    = lookupIp[OFF_BITS +: SET_BITS];
  assign lkTag    = lookupIp[OFF_BITS+SET_BITS +: TAG_BITS];
  assign upOff    = updIp[OFF_BITS-1:0];
  assign updSet   = updIp[OFF_BITS +: SET_BITS];
  assign upTag    = updIp[OFF_BITS+SET_BITS +: TAG_BITS];
  assign nextLine = {lookupIp[ADDR_W-1:OFF_BITS], OFF_BITS'(0)} + ADDR_W'(LINE_BYTES);

  if (ADDR_W > USED_BITS) begin : g_high
    logic unusedUpdHigh;
    assign unusedUpdHigh = ^updIp[ADDR_W-1:USED_BITS];
  end

  // Per-way reads of the looked-up set and the updated set
  logic [NUM_WAYS-1:0]               lkHit, lkPred, upMatch;
  logic [NUM_WAYS-1:0][OFF_BITS-1:0] lkOffs;
  logic [ADDR_W-1:0]                 lkTarget [NUM_WAYS];
  logic [1:0]                        lkKind   [NUM_WAYS];
  logic [HIST_BITS-1:0]              lkHist   [NUM_WAYS];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    assign lkHit[w]    = entValid[lkSet][w] && (entTag[lkSet][w] == lkTag);
    assign lkOffs[w]   = entOff[lkSet][w];
    assign lkTarget[w] = entTarget[lkSet][w];
    assign lkKind[w]   = entKind[lkSet][w];
    assign lkHist[w]   = entHist[lkSet][w];
    assign lkPred[w]   = (entKind[lkSet][w] != KIND_COND) || ctrTab[lkSet][entHist[lkSet][w]][1];
    assign upMatch[w]  = entValid[updSet][w] && (entTag[updSet][w] == upTag)
                         && (entOff[updSet][w] == upOff);
  end

  always_comb begin
    updHit    = 1'b0;
    updHitWay = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (upMatch[w]) begin
        updHit    = 1'b1;
        updHitWay = WAY_BITS'(w);
      end
    end
  end

  logic                pickFound;
  logic [WAY_BITS-1:0] pickWay;
  logic [OFF_BITS-1:0] pickOff;
  logic [NUM_WAYS-1:0] travVec;

  btb_pick #(.NUM_WAYS(NUM_WAYS), .OFF_BITS(OFF_BITS)) u_pick (
    .hitVec  (lkHit),
    .predVec (lkPred),
    .wayOff  (lkOffs),
    .fetchOff(lkOff),
    .found   (pickFound),
    .bestWay (pickWay),
    .bestOff (pickOff),
    .travVec (travVec)
  );

  // Training index: history saved at prediction time; a same-cycle lookup saves it first
  logic                 sameCycleShift;
  logic [HIST_BITS-1:0] trainIdx, trainHist, allocHist;

  always_comb begin
    sameCycleShift = strobe.lookupEn && (lkSet == updSet) && travVec[writeWay];
    trainIdx  = sameCycleShift ? entHist[updSet][writeWay] : entLast[updSet][writeWay];
    trainHist = {trainIdx[HIST_BITS-2:0], updTaken};
    allocHist = HIST_BITS'(updTaken);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        for (int w = 0; w < NUM_WAYS; w++) begin
          entValid[s][w]  <= 1'b0;
          entTag[s][w]    <= '0;
          entOff[s][w]    <= '0;
          entTarget[s][w] <= '0;
          entKind[s][w]   <= KIND_COND;
          entHist[s][w]   <= '0;
          entLast[s][w]   <= '0;
        end
        for (int c = 0; c < CTR_COUNT; c++) ctrTab[s][c] <= 2'b01;
      end
      predValid  <= 1'b0;
      predTaken  <= 1'b0;
      predTarget <= '0;
      predKind   <= KIND_COND;
      predOffset <= '0;
    end else begin
      predValid <= strobe.lookupEn;
      if (strobe.lookupEn) begin
        predTaken  <= pickFound;
        predTarget <= pickFound ? lkTarget[pickWay] : nextLine;
        predKind   <= pickFound ? lkKind[pickWay] : KIND_COND;
        predOffset <= pickFound ? pickOff : '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
          if (travVec[w]) begin
            entLast[lkSet][w] <= lkHist[w];
            entHist[lkSet][w] <= {lkHist[w][HIST_BITS-2:0], lkPred[w]};
          end
        end
      end
      if (strobe.trainEn) begin
        ctrTab[updSet][trainIdx]    <= satStep(ctrTab[updSet][trainIdx], updTaken);
        entHist[updSet][writeWay]   <= trainHist;
        entLast[updSet][writeWay]   <= trainHist;
        entTarget[updSet][writeWay] <= updTarget;
        entKind[updSet][writeWay]   <= updKind;
      end
      if (strobe.allocEn) begin
        entValid[updSet][writeWay]  <= 1'b1;
        entTag[updSet][writeWay]    <= upTag;
        entOff[updSet][writeWay]    <= upOff;
        entTarget[updSet][writeWay] <= updTarget;
        entKind[updSet][writeWay]   <= updKind;
        entHist[updSet][writeWay]   <= allocHist;
        entLast[updSet][writeWay]   <= allocHist;
        ctrTab[updSet][allocHist]   <= updTaken ? 2'b10 : 2'b01;
      end
    end
  end

endmodule

// File: rtl/btb_cluster.sv
module btb_cluster
  import btb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_WAYS   = 4,
  parameter int NUM_SETS   = 128,
  parameter int LINE_BYTES = 16,
  parameter int TAG_BITS   = 9,
  parameter int HIST_BITS  = 4,
  localparam int OFF_BITS  = $clog2(LINE_BYTES)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                lookupValid,
  input  logic [ADDR_W-1:0]   lookupIp,
  input  logic                updValid,
  input  logic [ADDR_W-1:0]   updIp,
  input  logic [ADDR_W-1:0]   updTarget,
  input  logic                updTaken,
  input  logic [1:0]          updKind,
  output logic                predValid,
  output logic                predTaken,
  output logic [ADDR_W-1:0]   predTarget,
  output logic [1:0]          predKind,
  output logic [OFF_BITS-1:0] predOffset
);

  localparam int SET_BITS = $clog2(NUM_SETS);
  localparam int WAY_BITS = $clog2(NUM_WAYS);

  btbStrobe_t          strobe;
  logic [WAY_BITS-1:0] writeWay, updHitWay;
  logic [SET_BITS-1:0] updSet;
  logic                updHit;

  btb_ctrl #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .lookupValid(lookupValid),
    .updValid   (updValid),
    .updSet     (updSet),
    .updHit     (updHit),
    .updHitWay  (updHitWay),
    .strobe     (strobe),
    .writeWay   (writeWay)
  );

  btb_datapath #(
    .ADDR_W(ADDR_W), .NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS),
    .LINE_BYTES(LINE_BYTES), .TAG_BITS(TAG_BITS), .HIST_BITS(HIST_BITS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .lookupIp  (lookupIp),
    .updIp     (updIp),
    .updTarget (updTarget),
    .updTaken  (updTaken),
    .updKind   (updKind),
    .strobe    (strobe),
    .writeWay  (writeWay),
    .updSet    (updSet),
    .updHit    (updHit),
    .updHitWay (updHitWay),
    .predValid (predValid),
    .predTaken (predTaken),
    .predTarget(predTarget),
    .predKind  (predKind),
    .predOffset(predOffset)
  );

endmodule

// File: rtl/btb_cluster_checker.sv
module btb_cluster_checker #(
  parameter int ADDR_W   = 32,
  parameter int OFF_BITS = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                lookupValid,
  input logic [ADDR_W-1:0]   lookupIp,
  input logic                predValid,
  input logic                predTaken,
  input logic [ADDR_W-1:0]   predTarget,
  input logic [1:0]          predKind,
  input logic [OFF_BITS-1:0] predOffset
);

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> predValid);

  assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> !predValid);

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> ($stable(predTarget) && $stable(predTaken)
                      && $stable(predKind) && $stable(predOffset)));

  assert_seq_target_R3: assert property (@(posedge clk) disable iff (!rstN)
    (predValid && !predTaken) |->
      (predTarget == ({$past(lookupIp[ADDR_W-1:OFF_BITS]), OFF_BITS'(0)}
                      + (ADDR_W'(1) << OFF_BITS))));

  assert_seq_fields_R3: assert property (@(posedge clk) disable iff (!rstN)
    (predValid && !predTaken) |-> (predKind == 2'b00 && predOffset == '0));

  assert_offset_floor_R4: assert property (@(posedge clk) disable iff (!rstN)
    (predValid && predTaken) |-> (predOffset >= $past(lookupIp[OFF_BITS-1:0])));

endmodule

bind btb_cluster btb_cluster_checker #(.ADDR_W(ADDR_W), .OFF_BITS(OFF_BITS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .lookupValid(lookupValid),
  .lookupIp   (lookupIp),
  .predValid  (predValid),
  .predTaken  (predTaken),
  .predTarget (predTarget),
  .predKind   (predKind),
  .predOffset (predOffset)
);

// File: tb/tb_btb_cluster.sv
module tb_btb_cluster;

  localparam int CLK_PERIOD = 10;
  localparam int NSETS = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lookupValid = 1'b0;
  logic [31:0] lookupIp = '0;
  logic        updValid = 1'b0;
  logic [31:0] updIp = '0;
  logic [31:0] updTarget = '0;
  logic        updTaken = 1'b0;
  logic [1:0]  updKind = 2'b00;
  logic        predValid, predTaken;
  logic [31:0] predTarget;
  logic [1:0]  predKind;
  logic [3:0]  predOffset;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  btb_cluster #(.NUM_SETS(NSETS)) dut (
    .clk(clk), .rstN(rstN),
    .lookupValid(lookupValid), .lookupIp(lookupIp),
    .updValid(updValid), .updIp(updIp), .updTarget(updTarget),
    .updTaken(updTaken), .updKind(updKind),
    .predValid(predValid), .predTaken(predTaken), .predTarget(predTarget),
    .predKind(predKind), .predOffset(predOffset)
  );

  // Reference state built from the requirements
  bit         mValid [NSETS][4];
  logic [8:0] mTag   [NSETS][4];
  logic [3:0] mOff   [NSETS][4];
  logic [31:0] mTgt  [NSETS][4];
  logic [1:0] mKind  [NSETS][4];
  logic [3:0] mHist  [NSETS][4];
  logic [3:0] mLast  [NSETS][4];
  logic [1:0] mCtr   [NSETS][16];
  int         mRr    [NSETS];

  function automatic logic [31:0] mkIp(input int tag, input int set, input int off,
                                       input logic [15:0] hi);
    return {hi, 9'(tag), 3'(set), 4'(off)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic mLookup(input logic [31:0] ip, output logic tk, output logic [31:0] tgt,
                         output logic [1:0] kd, output logic [3:0] of);
    int s = int'(ip[6:4]);
    bit cand [4];
    bit pr [4];
    bit found = 0;
    int bo = 16;
    int bw = 0;
    for (int w = 0; w < 4; w++) begin
      cand[w] = mValid[s][w] && mTag[s][w] == ip[15:7] && mOff[s][w] >= ip[3:0];
      pr[w] = (mKind[s][w] != 2'b00) || mCtr[s][mHist[s][w]][1];
      if (cand[w] && pr[w] && int'(mOff[s][w]) < bo) begin
        found = 1; bo = int'(mOff[s][w]); bw = w;
      end
    end
    tk = found;
    if (found) begin
      tgt = mTgt[s][bw]; kd = mKind[s][bw]; of = 4'(bo);
    end else begin
      tgt = {ip[31:4], 4'h0} + 32'd16; kd = 2'b00; of = 4'h0;
    end
    for (int w = 0; w < 4; w++) begin
      if (cand[w] && (!found || int'(mOff[s][w]) <= bo)) begin
        mLast[s][w] = mHist[s][w];
        mHist[s][w] = {mHist[s][w][2:0], pr[w]};
      end
    end
  endtask

  task automatic mUpdate(input logic [31:0] ip, input logic [31:0] tgt, input logic tk,
                         input logic [1:0] kd);
    int s = int'(ip[6:4]);
    int hw = -1;
    logic [3:0] idx, h;
    for (int w = 0; w < 4; w++)
      if (mValid[s][w] && mTag[s][w] == ip[15:7] && mOff[s][w] == ip[3:0]) hw = w;
    if (hw >= 0) begin
      idx = mLast[s][hw];
      if (tk) mCtr[s][idx] = (mCtr[s][idx] == 2'd3) ? 2'd3 : mCtr[s][idx] + 2'd1;
      else    mCtr[s][idx] = (mCtr[s][idx] == 2'd0) ? 2'd0 : mCtr[s][idx] - 2'd1;
      h = {idx[2:0], tk};
      mHist[s][hw] = h; mLast[s][hw] = h;
      mTgt[s][hw] = tgt; mKind[s][hw] = kd;
    end else begin
      hw = mRr[s];
      mRr[s] = (mRr[s] + 1) % 4;
      h = {3'b000, tk};
      mValid[s][hw] = 1; mTag[s][hw] = ip[15:7]; mOff[s][hw] = ip[3:0];
      mTgt[s][hw] = tgt; mKind[s][hw] = kd; mHist[s][hw] = h; mLast[s][hw] = h;
      mCtr[s][h] = tk ? 2'b10 : 2'b01;
    end
  endtask

  // One cycle of stimulus, called at a falling edge; result sampled at the next one
  task automatic doOp(input bit lv, input logic [31:0] lip, input bit uv,
                      input logic [31:0] uip, input logic [31:0] utgt, input bit utk,
                      input logic [1:0] ukd, input string req);
    logic eTk;
    logic [31:0] eTgt;
    logic [1:0] eKd;
    logic [3:0] eOf;
    lookupValid = lv; lookupIp = lip;
    updValid = uv; updIp = uip; updTarget = utgt; updTaken = utk; updKind = ukd;
    if (lv) mLookup(lip, eTk, eTgt, eKd, eOf);
    if (uv) mUpdate(uip, utgt, utk, ukd);
    @(posedge clk);
    @(negedge clk);
    lookupValid = 1'b0; updValid = 1'b0;
    if (lv)
      check(predValid && {predTaken, predKind, predOffset, predTarget} == {eTk, eKd, eOf, eTgt},
            req, {25'h0, predValid, predTaken, predKind, predOffset, predTarget},
            {25'h0, 1'b1, eTk, eKd, eOf, eTgt});
  endtask

  task automatic lk(input logic [31:0] ip, input string req);
    doOp(1'b1, ip, 1'b0, '0, '0, 1'b0, 2'b00, req);
  endtask

  task automatic up(input logic [31:0] ip, input logic [31:0] tgt, input bit tk,
                    input logic [1:0] kd);
    doOp(1'b0, '0, 1'b1, ip, tgt, tk, kd, "R9");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr = 32'h1234_5678;
    logic [31:0] holdTgt;
    for (int s = 0; s < NSETS; s++) begin
      mRr[s] = 0;
      for (int w = 0; w < 4; w++) begin
        mValid[s][w] = 0; mTag[s][w] = '0; mOff[s][w] = '0; mTgt[s][w] = '0;
        mKind[s][w] = '0; mHist[s][w] = '0; mLast[s][w] = '0;
      end
      for (int c = 0; c < 16; c++) mCtr[s][c] = 2'b01;
    end

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11: reset state
    check(predValid == 1'b0 && predTaken == 1'b0, "R11", {62'h0, predValid, predTaken}, 64'h0);

    // R11 / R3: empty store misses everywhere, including the last line offset
    for (int s = 0; s < NSETS; s++) lk(mkIp(s + 3, s, 15, 16'h00A0), "R11");
    lk(mkIp(511, 7, 15, 16'hFFFF), "R3");

    // R1: outputs hold while idle
    holdTgt = predTarget;
    repeat (3) @(negedge clk);
    check(predValid == 1'b0 && predTarget == holdTgt, "R1", {31'h0, predValid, predTarget},
          {32'h0, holdTgt});

    // Four branches in one line: R4, R5, R6, R7 across every fetch offset
    up(mkIp(5, 2, 10, 0), 32'hA000_0010, 1'b1, 2'b11);
    up(mkIp(5, 2, 3, 0),  32'hB000_0020, 1'b1, 2'b00);
    up(mkIp(5, 2, 7, 0),  32'hC000_0030, 1'b0, 2'b00);
    up(mkIp(5, 2, 13, 0), 32'hD000_0040, 1'b1, 2'b01);
    for (int o = 0; o < 16; o++) lk(mkIp(5, 2, o, 0), (o > 3) ? "R4" : "R5");
    for (int o = 0; o < 16; o++) lk(mkIp(5, 2, o, 0), "R7");

    // R2: high address bits ignored
    lk(mkIp(5, 2, 0, 16'hBEEF), "R2");
    lk(mkIp(6, 2, 0, 0), "R2");

    // R6: return and call always taken
    up(mkIp(2, 1, 2, 0), 32'h0000_2222, 1'b0, 2'b10);
    up(mkIp(2, 1, 9, 0), 32'h0000_9999, 1'b0, 2'b01);
    for (int o = 0; o < 16; o++) lk(mkIp(2, 1, o, 0), "R6");

    // R8: history shifting and repair on one conditional branch
    up(mkIp(9, 4, 6, 0), 32'h4444_0000, 1'b0, 2'b00);
    for (int i = 0; i < 16; i++) begin
      lk(mkIp(9, 4, 0, 0), "R8");
      up(mkIp(9, 4, 6, 0), 32'h4444_0000, (i % 3) != 2, 2'b00);
    end

    // R9: fifth branch in one set evicts the first
    for (int t = 1; t <= 5; t++) up(mkIp(t, 6, 0, 0), 32'h6000_0000 + 32'(t), 1'b1, 2'b11);
    for (int t = 1; t <= 5; t++) lk(mkIp(t, 6, 0, 0), "R9");
    check(1'b1, "R9", 64'h0, 64'h0);

    // R10: lookup and allocation in the same cycle
    doOp(1'b1, mkIp(7, 3, 0, 0), 1'b1, mkIp(7, 3, 4, 0), 32'h7777_0000, 1'b1, 2'b10, "R10");
    lk(mkIp(7, 3, 0, 0), "R10");
    doOp(1'b1, mkIp(7, 3, 0, 0), 1'b1, mkIp(7, 3, 4, 0), 32'h7777_1111, 1'b1, 2'b11, "R10");
    lk(mkIp(7, 3, 0, 0), "R10");

    // Mixed stream over a crowded corner of the store
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a, b;
      lfsr = {lfsr[30:0], 1'b0} ^ (lfsr[31] ? 32'h04C1_1DB7 : 32'h0);
      a = lfsr;
      lfsr = {lfsr[30:0], 1'b0} ^ (lfsr[31] ? 32'h04C1_1DB7 : 32'h0);
      b = lfsr;
      doOp(a[9] | a[10], mkIp(1 + int'(a[0]), int'(a[1]), int'(a[5:2]), a[31:16]),
           b[11], mkIp(1 + int'(b[0]), int'(b[1]), int'(b[5:2]), b[31:16]),
           {b[31:12], 12'h0}, b[8], b[7:6], "R5");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule